// File: doc/BRIEF.md
# Channel Status and User Bit Triple Buffer

This block holds the channel status bits and user bits of a stereo digital audio stream while they pass from a receiver to a transmitter. It uses two identical sets of storage, one for channel status and one for user bits. Each set has three stages: a capture stage that a receiver fills one bit at a time, an edit stage that a host can read and patch a byte at a time, and a transmit stage that an encoder drains one bit at a time. Every stage holds one full block of 384 bits. For channel status, those 384 bits are 192 frames, stored alternately as subframe A and then subframe B.

When the capture stage completes a block, the whole block moves into the edit stage. When the encoder has consumed the last bit of the transmit stage, the edit stage is copied into the transmit stage. The host can therefore change any bit between reception and retransmission. A select input chooses which set the host port reaches. Both the receive and transmit bit streams advance only while a run-enable input is high. The host port works at all times.

Top module: `chstat_buffer`

## Requirements
- R1: After reset, every edit byte of both sets reads 0x00, `txCsBit` and `txUserBit` are 0, and `hostWrLost` is 0.
- R2: While `runEn` is high, each cycle with `rxValid` high stores `rxCsBit` and `rxUserBit` at capture index n, where n counts accepted bits from 0. For channel status, even n is subframe A and odd n is subframe B of frame n/2. Accepting index 383 moves the complete block into the edit stage of both sets at that clock edge. Index n is then visible as bit n%8 of edit byte n/8.
- R3: A partly filled capture block changes no edit byte.
- R4: `hostSel`=0 selects the channel status set and `hostSel`=1 selects the user set. `hostRdData` combinationally shows edit byte `hostAddr` of the selected set. `hostWrEn` writes `hostWrData` into that byte at the clock edge and leaves the other set unchanged.
- R5: For `hostAddr` from 48 to 63, writes change nothing and `hostRdData` reads 0x00.
- R6: A host write that is in range and falls in the same cycle as a capture-to-edit move is discarded, so the edit stage holds the captured block. In that case `hostWrLost` is high for exactly the following cycle.
- R7: `txCsBit` and `txUserBit` show the transmit bit at a read index that starts at 0 and advances on each cycle with `runEn` and `txReq` high. The request that consumes index 383 loads the transmit stage with the edit contents held before that edge, and the read index returns to 0.
- R8: While `runEn` is low, `rxValid` and `txReq` have no effect. Host reads and writes still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Enables the receive and transmit bit streams |
| rxValid | input | 1 | A recovered bit pair is present |
| rxCsBit | input | 1 | Recovered channel status bit |
| rxUserBit | input | 1 | Recovered user bit |
| txReq | input | 1 | Encoder consumes the current bit pair |
| txCsBit | output | 1 | Channel status bit for the encoder |
| txUserBit | output | 1 | User bit for the encoder |
| hostSel | input | 1 | 0 selects channel status, 1 selects user bits |
| hostAddr | input | 6 | Edit byte address |
| hostWrEn | input | 1 | Host byte write strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Selected edit byte |
| hostWrLost | output | 1 | Pulses after a host write lost to a block move |

## Verification
A capture pointer that is off by one shows up in one of two ways. Either the block moves one bit early, which changes the edit bytes at a partial-block read, or every captured bit lands shifted in the byte read back right after the 384th bit. A transmit pointer fault shows as a wrong bit on the encoder outputs at the first affected request. A wrong snapshot shows only after a full 384-request round. A stage that ignores `runEn` is caught after one block of ignored strobes, because a spurious move then alters the host-visible bytes.

// File: rtl/chstat_pkg.sv
package chstat_pkg;

  localparam int NUM_SETS = 2;
  localparam int SET_CS   = 0;
  localparam int SET_USER = 1;

  typedef struct packed {
    logic capWr;       // store one receive bit pair
    logic capLoad;     // capture block complete: move to edit stage
    logic txAdv;       // encoder consumed a bit pair
    logic txLoad;      // transmit block drained: reload from edit stage
    logic hostWr;      // host byte write takes effect
    logic hostAddrOk;  // host address lies inside the block
  } bufStrobe_t;

endpackage

// File: rtl/chstat_ctrl.sv
module chstat_ctrl
  import chstat_pkg::*;
#(
  parameter int BLOCK_BITS = 384,
  parameter int BYTE_W     = 8,
  localparam int PTR_W     = $clog2(BLOCK_BITS),
  localparam int NUM_BYTES = BLOCK_BITS / BYTE_W,
  localparam int ADDR_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              rxValid,
  input  logic              txReq,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  output bufStrobe_t        strb,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic              hostWrLost
);

  localparam logic [PTR_W-1:0] LAST_BIT = PTR_W'(BLOCK_BITS - 1);

  logic [PTR_W-1:0] wrPtrQ, rdPtrQ;
  logic             lostQ;

  always_comb begin
    strb            = '0;
    strb.capWr      = runEn & rxValid;
    strb.capLoad    = strb.capWr & (wrPtrQ == LAST_BIT);
    strb.txAdv      = runEn & txReq;
    strb.txLoad     = strb.txAdv & (rdPtrQ == LAST_BIT);
    strb.hostAddrOk = {1'b0, hostAddr} < (ADDR_W + 1)'(NUM_BYTES);
    // a block move rewrites every edit byte, so it overrides any host write
    strb.hostWr     = hostWrEn & strb.hostAddrOk & ~strb.capLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      lostQ  <= 1'b0;
    end else begin
      if (strb.capWr) wrPtrQ <= strb.capLoad ? '0 : wrPtrQ + PTR_W'(1);
      if (strb.txAdv) rdPtrQ <= strb.txLoad ? '0 : rdPtrQ + PTR_W'(1);
      lostQ <= hostWrEn & strb.hostAddrOk & strb.capLoad;
    end
  end

  assign wrPtr      = wrPtrQ;
  assign rdPtr      = rdPtrQ;
  assign hostWrLost = lostQ;

endmodule

// File: rtl/chstat_dp.sv
module chstat_dp
  import chstat_pkg::*;
#(
  parameter int BLOCK_BITS = 384,
  parameter int BYTE_W     = 8,
  localparam int PTR_W     = $clog2(BLOCK_BITS),
  localparam int NUM_BYTES = BLOCK_BITS / BYTE_W,
  localparam int ADDR_W    = $clog2(NUM_BYTES)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  bufStrobe_t                         strb,
  input  logic [PTR_W-1:0]                   wrPtr,
  input  logic [PTR_W-1:0]                   rdPtr,
  input  logic [NUM_SETS-1:0]                rxBits,
  input  logic                               hostSel,
  input  logic [ADDR_W-1:0]                  hostAddr,
  input  logic [BYTE_W-1:0]                  hostWrData,
  output logic [NUM_SETS-1:0]                txBits,
  output logic [NUM_SETS-1:0][BYTE_W-1:0]    rdBytes
);

  logic [ADDR_W-1:0] safeAddr;
  logic [PTR_W-1:0]  byteOfs;

  assign safeAddr = strb.hostAddrOk ? hostAddr : '0;
  assign byteOfs  = PTR_W'(safeAddr) * PTR_W'(BYTE_W);

  for (genvar g = 0; g < NUM_SETS; g++) begin : gSet
    logic [BLOCK_BITS-1:0] capBuf, capNext, editBuf, txBuf;
    logic                  hostHere;

    assign hostHere = strb.hostWr & (hostSel == 1'(g));

    always_comb begin
      capNext = capBuf;
      if (strb.capWr) capNext[wrPtr] = rxBits[g];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        capBuf  <= '0;
        editBuf <= '0;
        txBuf   <= '0;
      end else begin
        if (strb.capWr) capBuf <= capNext;
        if (strb.capLoad)  editBuf <= capNext;
        else if (hostHere) editBuf[byteOfs +: BYTE_W] <= hostWrData;
        if (strb.txLoad) txBuf <= editBuf;
      end
    end

    assign txBits[g]  = txBuf[rdPtr];
    assign rdBytes[g] = strb.hostAddrOk ? editBuf[byteOfs +: BYTE_W] : '0;
  end

endmodule

// File: rtl/chstat_buffer.sv
module chstat_buffer
  import chstat_pkg::*;
#(
  parameter int BLOCK_BITS = 384,
  parameter int BYTE_W     = 8
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         runEn,
  input  logic                                         rxValid,
  input  logic                                         rxCsBit,
  input  logic                                         rxUserBit,
  input  logic                                         txReq,
  output logic                                         txCsBit,
  output logic                                         txUserBit,
  input  logic                                         hostSel,
  input  logic [$clog2(BLOCK_BITS/BYTE_W)-1:0]         hostAddr,
  input  logic                                         hostWrEn,
  input  logic [BYTE_W-1:0]                            hostWrData,
  output logic [BYTE_W-1:0]                            hostRdData,
  output logic                                         hostWrLost
);

  localparam int PTR_W = $clog2(BLOCK_BITS);

  bufStrobe_t                          strb;
  logic [PTR_W-1:0]                    wrPtr, rdPtr;
  logic [NUM_SETS-1:0]                 rxBits, txBits;
  logic [NUM_SETS-1:0][BYTE_W-1:0]     rdBytes;

  assign rxBits[SET_CS]   = rxCsBit;
  assign rxBits[SET_USER] = rxUserBit;

  chstat_ctrl #(.BLOCK_BITS(BLOCK_BITS), .BYTE_W(BYTE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .rxValid(rxValid), .txReq(txReq),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .strb(strb),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .hostWrLost(hostWrLost)
  );

  chstat_dp #(.BLOCK_BITS(BLOCK_BITS), .BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .rxBits(rxBits), .hostSel(hostSel), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .txBits(txBits), .rdBytes(rdBytes)
  );

  assign txCsBit    = txBits[SET_CS];
  assign txUserBit  = txBits[SET_USER];
  assign hostRdData = rdBytes[hostSel];

endmodule

// File: rtl/chstat_buffer_chk.sv
module chstat_buffer_chk #(
  parameter int BLOCK_BITS = 384,
  parameter int BYTE_W     = 8,
  localparam int NUM_BYTES = BLOCK_BITS / BYTE_W,
  localparam int ADDR_W    = $clog2(NUM_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic              rxValid,
  input logic              txReq,
  input logic              txCsBit,
  input logic              txUserBit,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostWrEn,
  input logic [BYTE_W-1:0] hostRdData,
  input logic              hostWrLost
);

  // R5: out-of-range addresses read as zero
  a_r5_oob_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, hostAddr} >= (ADDR_W + 1)'(NUM_BYTES)) |-> (hostRdData == '0));

  // R6: a lost-write flag needs a host write that met an accepted receive bit
  a_r6_lost_needs_conflict: assert property (@(posedge clk) disable iff (!rstN)
    hostWrLost |-> $past(runEn && rxValid && hostWrEn));

  // R6: the flag lasts a single cycle
  a_r6_lost_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    hostWrLost |=> !hostWrLost);

  // R7: encoder outputs move only on an accepted request
  a_r7_tx_holds_without_req: assert property (@(posedge clk) disable iff (!rstN)
    !(runEn && txReq) |=> ($stable(txCsBit) && $stable(txUserBit)));

  // R8: with run disabled no block move, so no lost write
  a_r8_idle_no_lost: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !hostWrLost);

endmodule

bind chstat_buffer chstat_buffer_chk #(.BLOCK_BITS(BLOCK_BITS), .BYTE_W(BYTE_W)) i_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .rxValid(rxValid), .txReq(txReq),
  .txCsBit(txCsBit), .txUserBit(txUserBit), .hostAddr(hostAddr),
  .hostWrEn(hostWrEn), .hostRdData(hostRdData), .hostWrLost(hostWrLost)
);

// File: tb/test_chstat_buffer.sv
module test_chstat_buffer;

  localparam int BITS   = 384;
  localparam int NBYTES = BITS / 8;
  localparam int CLK_NS = 8;

  logic       clk = 1'b0;
  logic       rstN, runEn, rxValid, rxCsBit, rxUserBit, txReq;
  logic       txCsBit, txUserBit, hostSel, hostWrEn, hostWrLost;
  logic [5:0] hostAddr;
  logic [7:0] hostWrData, hostRdData;

  int nChecks = 0;
  int nFails  = 0;

  // bench model of the three stages
  logic [BITS-1:0] capCs = '0, capUs = '0, edCs = '0, edUs = '0, txCs = '0, txUs = '0;
  int wp = 0;
  int rp = 0;
  logic [1:0] txQ[$];

  always #(CLK_NS / 2) clk = ~clk;

  chstat_buffer i_chstat_buffer (
    .clk(clk), .rstN(rstN), .runEn(runEn), .rxValid(rxValid), .rxCsBit(rxCsBit),
    .rxUserBit(rxUserBit), .txReq(txReq), .txCsBit(txCsBit), .txUserBit(txUserBit),
    .hostSel(hostSel), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostWrLost(hostWrLost)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic csPat(int n, int blk);
    return ((n * 5 + blk * 3) % 7) < 3;
  endfunction

  function automatic logic usPat(int n, int blk);
    return ((n * 3 + blk) % 5) == 1;
  endfunction

  function automatic logic [7:0] modelByte(logic sel, int addr);
    if (addr >= NBYTES) return 8'h00;
    return sel ? edUs[addr*8 +: 8] : edCs[addr*8 +: 8];
  endfunction

  task automatic clearStrobes();
    rxValid  = 1'b0;
    txReq    = 1'b0;
    hostWrEn = 1'b0;
  endtask

  task automatic rxStep(input logic cs, input logic us, input logic run);
    @(negedge clk);
    clearStrobes();
    rxValid = 1'b1; runEn = run; rxCsBit = cs; rxUserBit = us;
    if (run) begin
      capCs[wp] = cs; capUs[wp] = us;
      wp++;
      if (wp == BITS) begin edCs = capCs; edUs = capUs; wp = 0; end
    end
  endtask

  // driver: pushes the expected encoder bits, then issues the request
  task automatic txStep(input logic run);
    @(negedge clk);
    clearStrobes();
    txQ.push_back({txCs[rp], txUs[rp]});
    txReq = 1'b1; runEn = run;
    if (run) begin
      rp++;
      if (rp == BITS) begin txCs = edCs; txUs = edUs; rp = 0; end
    end
  endtask

  task automatic hostWrite(input logic sel, input int addr, input logic [7:0] data);
    @(negedge clk);
    clearStrobes();
    hostWrEn = 1'b1; hostSel = sel; hostAddr = 6'(addr); hostWrData = data;
    if (addr < NBYTES) begin
      if (sel) edUs[addr*8 +: 8] = data; else edCs[addr*8 +: 8] = data;
    end
  endtask

  task automatic readChk(input string req, input logic sel, input int addr);
    @(negedge clk);
    clearStrobes();
    hostSel = sel; hostAddr = 6'(addr);
    #1;
    chk(req, 32'(hostRdData), 32'(modelByte(sel, addr)));
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < NBYTES; a++) begin
      readChk(req, 1'b0, a);
      readChk(req, 1'b1, a);
    end
  endtask

  // monitor: compares encoder outputs against the queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (txQ.size() > 0) begin
        logic [1:0] e;
        e = txQ.pop_front();
        chk("R7 encoder bits", 32'({txCsBit, txUserBit}), 32'(e));
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; runEn = 1'b0; rxCsBit = 1'b0; rxUserBit = 1'b0;
    hostSel = 1'b0; hostAddr = '0; hostWrData = '0;
    clearStrobes();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk); #2;
    chk("R1 txCsBit", 32'(txCsBit), 0);
    chk("R1 txUserBit", 32'(txUserBit), 0);
    chk("R1 hostWrLost", 32'(hostWrLost), 0);
    readAll("R1 edit bytes zero");

    // R4 and R8: host access with run disabled, set select
    hostWrite(1'b0, 5, 8'hA5);
    hostWrite(1'b1, 5, 8'h3C);
    hostWrite(1'b0, 47, 8'h81);
    readChk("R4 cs byte 5", 1'b0, 5);
    readChk("R4 user byte 5", 1'b1, 5);
    readChk("R8 host write works with run off", 1'b0, 47);
    readChk("R4 user byte 47 untouched", 1'b1, 47);

    // R5: out-of-range addresses
    hostWrite(1'b0, 50, 8'hFF);
    hostWrite(1'b1, 63, 8'hFF);
    readChk("R5 oob read cs", 1'b0, 50);
    readChk("R5 oob read user", 1'b1, 63);
    readAll("R5 no aliasing");

    // R8: a full block of receive strobes with run off is ignored
    for (int n = 0; n < BITS + 16; n++) rxStep(1'b1, 1'b1, 1'b0);
    readAll("R8 rx ignored");

    // R3 then R2: block 1, with ignored gaps
    for (int n = 0; n < BITS - 1; n++) begin
      if (n % 50 == 0) rxStep(1'b1, 1'b1, 1'b0);
      rxStep(csPat(n, 1), usPat(n, 1), 1'b1);
    end
    readAll("R3 partial block invisible");
    rxStep(csPat(BITS - 1, 1), usPat(BITS - 1, 1), 1'b1);
    readAll("R2 block captured, A even B odd");

    // R6: block 2 completes in the same cycle as a host write
    for (int n = 0; n < BITS - 1; n++) rxStep(csPat(n, 2), usPat(n, 2), 1'b1);
    @(negedge clk);
    clearStrobes();
    rxValid = 1'b1; runEn = 1'b1;
    rxCsBit = csPat(BITS - 1, 2); rxUserBit = usPat(BITS - 1, 2);
    hostWrEn = 1'b1; hostSel = 1'b0; hostAddr = 6'd3; hostWrData = 8'h5A;
    capCs[wp] = rxCsBit; capUs[wp] = rxUserBit; wp = 0;
    edCs = capCs; edUs = capUs;
    @(negedge clk);
    clearStrobes();
    #2;
    chk("R6 lost flag set", 32'(hostWrLost), 1);
    @(negedge clk);
    #2;
    chk("R6 lost flag one cycle", 32'(hostWrLost), 0);
    readChk("R6 transfer wins", 1'b0, 3);
    readAll("R6 edit holds block 2");

    // R7 and R8: first round drains reset contents, second carries the snapshot
    for (int n = 0; n < BITS; n++) txStep(1'b1);
    for (int n = 0; n < BITS; n++) begin
      if (n % 40 == 7) txStep(1'b0);
      if (n == 100) hostWrite(1'b1, 0, 8'hC3);
      txStep(1'b1);
    end
    for (int n = 0; n < 12; n++) txStep(1'b1);

    @(negedge clk);
    clearStrobes();
    @(negedge clk);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule